// File: doc/BRIEF.md
# Clocked Serial Master Receiver

This block is the receive half of a clocked serial port acting as bus master. While receiving, it generates the serial clock itself from a 16-bit divider of the system clock. It captures one data bit per serial clock period and builds words of eight or nine bits, least significant bit first. When a word is complete, the block places it in a holding register and raises a completion flag. The host reads the holding register and acknowledges it with a read strobe.

Two enables start reception. A self-clearing single-word request receives one word and then stops. A level continuous enable receives words back to back for as long as it stays high, and it takes priority when both are active. If a finished word finds the previous one still unread, the block keeps the old word, raises an overrun flag and holds the serial clock idle. It resumes only after the continuous enable falls from high to low.

Top module: `sync_rx_master`

## Requirements
- R1: Reception starts on the cycle after `port_en` is high, `cont_en` or the pending single request is high, and `overrun` is low. The start moves `sclk` to its active level. A single request raised during an overrun stays pending and starts once the overrun clears.
- R2: A one-cycle pulse on `single_set` sets `single_pending`. Exactly one word is then received, with eight active clock phases for an 8-bit word. `single_pending` clears when that word completes, and `sclk` stays idle afterwards.
- R3: While `cont_en` is high, words are received back to back. Lowering `cont_en` in the middle of a word abandons that word, returns `sclk` to idle and raises no completion. The next reception starts from bit 0.
- R4: When `single_set` and `cont_en` are both active, continuous mode applies. `single_pending` clears after the first word, and further words follow without a new request.
- R5: `sdata` is captured at the end of each active half-period, when `sclk` leaves its active level. The first captured bit lands in `rd_data[0]`.
- R6: With `nine_en` = 1 a word is nine bits long and its last bit appears on `rd_bit9`. With `nine_en` = 0 a word is eight bits long and `rd_bit9` reads 0.
- R7: `done_flag` rises when a completed word is loaded and falls after a `rd_strobe` pulse. `irq` is high only while both `done_flag` and `irq_en` are high.
- R8: `sclk` idles at the level of `clk_pol` and is at the inverse level during the active half of each bit.
- R9: Each serial bit lasts 2×(`divisor`+1) system clocks, split into equal active and idle halves.
- R10: If a word completes while `done_flag` is high and no read strobe arrives in the same cycle, `overrun` is set, `rd_data` keeps the earlier word, and `sclk` stays idle with no further reception.
- R11: `overrun` is cleared by a high-to-low transition of `cont_en` and by nothing else while the port is enabled. Reading the data does not clear it.
- R12: After reset, or on any cycle with `port_en` low, `sclk` sits at idle and `done_flag`, `overrun` and `single_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low forces idle and clears flags |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_set | input | 1 | One-cycle request for a single word |
| nine_en | input | 1 | Selects nine-bit words |
| clk_pol | input | 1 | Idle level of the serial clock |
| irq_en | input | 1 | Interrupt enable for completion |
| divisor | input | 16 | Baud divider value |
| sdata | input | 1 | Serial data line |
| rd_strobe | input | 1 | Host read acknowledge |
| sclk | output | 1 | Generated serial clock |
| rd_data | output | 8 | Received data, low eight bits |
| rd_bit9 | output | 1 | Ninth received bit |
| done_flag | output | 1 | Word complete and unread |
| irq | output | 1 | Gated completion interrupt |
| overrun | output | 1 | Overrun error |
| single_pending | output | 1 | Single request not yet finished |

## Verification
The bench checks that a single request yields exactly eight active clock phases. A design that failed to clear the request would keep clocking words. It drops the continuous enable in the middle of a word and then restarts reception: a bit counter left stale would misalign the next word. It forces an overrun and checks three things: the held word survives, the clock stays frozen even when a new single request arrives, and a read alone does not clear the error. It also checks that a request left pending then runs once the continuous enable falls. Polarity inversion, ninth-bit placement at the fastest divider, the interrupt gate and shutdown through the port enable each have their own scenario.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    // Per-cycle timing strobes from the divider
    typedef struct packed {
        logic sample;   // last cycle of the active half: capture sdata
        logic active;   // serial clock is in its active half
    } baud_tick_t;

    // Host-visible flag set
    typedef struct packed {
        logic done;
        logic overrun;
        logic single;
    } rx_flags_t;

    function automatic logic sclk_level(input logic pol, input logic active);
        return pol ^ active;
    endfunction

endpackage

// File: rtl/srx_baud.sv
`timescale 1ns/1ps
module srx_baud
    import srx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output baud_tick_t       tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;   // 0: active half, 1: idle half
    logic             half_end;

    assign half_end = (cnt_q == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            div_q   <= divisor;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (half_end) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick.active = run & ~phase_q;
        tick.sample = run & ~phase_q & half_end;
    end

endmodule

// File: rtl/srx_shift.sv
`timescale 1ns/1ps
module srx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              sdata,
    input  logic              nine_en,
    output logic              word_done,
    output logic [DATA_W-1:0] word_data,
    output logic              word_bit9
);

    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

    logic [SH_W-1:0]  sh_q, sh_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] last_idx;
    logic             done_n;

    assign last_idx = nine_en ? LAST9 : LAST8;

    always_comb begin
        sh_n   = sh_q;
        cnt_n  = cnt_q;
        done_n = 1'b0;
        if (clear) begin
            sh_n  = '0;
            cnt_n = '0;
        end else if (sample) begin
            if (cnt_q == '0) begin
                sh_n = '0;
            end
            for (int i = 0; i < SH_W; i++) begin
                if (cnt_q == CNT_W'(i)) begin
                    sh_n[i] = sdata;
                end
            end
            if (cnt_q == last_idx) begin
                cnt_n  = '0;
                done_n = 1'b1;
            end else begin
                cnt_n  = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            cnt_q     <= '0;
            word_done <= 1'b0;
        end else begin
            sh_q      <= sh_n;
            cnt_q     <= cnt_n;
            word_done <= done_n;
        end
    end

    assign word_data = sh_q[DATA_W-1:0];
    assign word_bit9 = nine_en & sh_q[DATA_W];

endmodule

// File: rtl/srx_ctrl.sv
`timescale 1ns/1ps
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              cont_en,
    input  logic              single_set,
    input  logic              rd_strobe,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_bit9,
    output logic              run,
    output rx_flags_t         flags,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9
);

    rx_state_e st_q, st_n;
    rx_flags_t fl_q, fl_n;
    logic      cont_q;
    logic      cont_fall;
    logic      wd_ovr;
    logic      wd_load;
    logic      want;

    assign cont_fall = cont_q & ~cont_en;
    assign wd_ovr    = word_done & fl_q.done & ~rd_strobe;
    assign wd_load   = word_done & ~wd_ovr & ~fl_q.overrun;

    always_comb begin
        fl_n = fl_q;
        if (!port_en) begin
            fl_n = '0;
        end else begin
            if (cont_fall) fl_n.overrun = 1'b0;
            if (wd_ovr)    fl_n.overrun = 1'b1;
            if (wd_load)        fl_n.done = 1'b1;
            else if (rd_strobe) fl_n.done = 1'b0;
            if (word_done)  fl_n.single = 1'b0;
            if (single_set) fl_n.single = 1'b1;
        end
        want = port_en & (cont_en | fl_n.single) & ~fl_n.overrun;
        st_n = want ? RX_RUN : RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            fl_q    <= '0;
            cont_q  <= 1'b0;
            rd_data <= '0;
            rd_bit9 <= 1'b0;
        end else begin
            st_q   <= st_n;
            fl_q   <= fl_n;
            cont_q <= cont_en;
            if (wd_load) begin
                rd_data <= word_data;
                rd_bit9 <= word_bit9;
            end
        end
    end

    assign run   = (st_q == RX_RUN);
    assign flags = fl_q;

endmodule

// File: rtl/sync_rx_master.sv
`timescale 1ns/1ps
module sync_rx_master
    import srx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              cont_en,
    input  logic              single_set,
    input  logic              nine_en,
    input  logic              clk_pol,
    input  logic              irq_en,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              sdata,
    input  logic              rd_strobe,
    output logic              sclk,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              done_flag,
    output logic              irq,
    output logic              overrun,
    output logic              single_pending
);

    baud_tick_t        tick;
    rx_flags_t         flags;
    logic              run;
    logic              word_done;
    logic [DATA_W-1:0] word_data;
    logic              word_bit9;

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .divisor (divisor),
        .tick    (tick)
    );

    srx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (~run),
        .sample    (tick.sample),
        .sdata     (sdata),
        .nine_en   (nine_en),
        .word_done (word_done),
        .word_data (word_data),
        .word_bit9 (word_bit9)
    );

    srx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .cont_en    (cont_en),
        .single_set (single_set),
        .rd_strobe  (rd_strobe),
        .word_done  (word_done),
        .word_data  (word_data),
        .word_bit9  (word_bit9),
        .run        (run),
        .flags      (flags),
        .rd_data    (rd_data),
        .rd_bit9    (rd_bit9)
    );

    assign sclk           = sclk_level(clk_pol, tick.active);
    assign done_flag      = flags.done;
    assign overrun        = flags.overrun;
    assign single_pending = flags.single;
    assign irq            = flags.done & irq_en;

endmodule

// File: rtl/sync_rx_master_chk.sv
`timescale 1ns/1ps
module sync_rx_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              port_en,
    input logic              cont_en,
    input logic              clk_pol,
    input logic              rd_strobe,
    input logic              sclk,
    input logic              done_flag,
    input logic              overrun,
    input logic [DATA_W-1:0] rd_data
);

    // R12
    port_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> sclk == clk_pol);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_flag && !rd_strobe && port_en |=> done_flag);

    // R10
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $stable(rd_data));

    // R10
    ovr_clock_idle_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> sclk == clk_pol);

    // R11
    ovr_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(overrun) && $past(port_en) |-> $past(cont_en, 2) && !$past(cont_en));

endmodule

bind sync_rx_master sync_rx_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .cont_en   (cont_en),
    .clk_pol   (clk_pol),
    .rd_strobe (rd_strobe),
    .sclk      (sclk),
    .done_flag (done_flag),
    .overrun   (overrun),
    .rd_data   (rd_data)
);

// File: tb/sync_rx_master_tb.sv
`timescale 1ns/1ps
module sync_rx_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic        cont_en = 1'b0;
    logic        single_set = 1'b0;
    logic        nine_en = 1'b0;
    logic        clk_pol = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] divisor = 16'd3;
    logic        sdata = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        sclk;
    logic [7:0]  rd_data;
    logic        rd_bit9;
    logic        done_flag;
    logic        irq;
    logic        overrun;
    logic        single_pending;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [8:0] words [0:7];
    int w_idx = 0, b_idx = 0, word_len = 8;
    int act_edges = 0, t_prev = 0, t_last = 0;

    sync_rx_master u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .cont_en(cont_en),
        .single_set(single_set), .nine_en(nine_en), .clk_pol(clk_pol),
        .irq_en(irq_en), .divisor(divisor), .sdata(sdata),
        .rd_strobe(rd_strobe), .sclk(sclk), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .done_flag(done_flag), .irq(irq),
        .overrun(overrun), .single_pending(single_pending)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Serial data source: present the next bit when sclk enters its active level
    initial begin
        logic prev_sclk;
        prev_sclk = 1'b0;
        forever begin
            @(negedge clk);
            if (sclk == ~clk_pol && prev_sclk == clk_pol) begin
                sdata = words[w_idx % 8][b_idx];
                act_edges = act_edges + 1;
                t_prev = t_last;
                t_last = cyc;
                b_idx = b_idx + 1;
                if (b_idx == word_len) begin
                    b_idx = 0;
                    w_idx = w_idx + 1;
                end
            end
            prev_sclk = sclk;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic prep(input int len);
        w_idx = 0; b_idx = 0; word_len = len; act_edges = 0;
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done_flag && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " completion seen"}, 32'(done_flag), 32'd1);
    endtask

    task automatic wait_ovr(input string req);
        int k;
        k = 0;
        while (!overrun && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " overrun seen"}, 32'(overrun), 32'd1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic do_single();
        @(negedge clk) single_set = 1'b1;
        @(negedge clk) single_set = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset sclk", 32'(sclk), 32'd0);
        chk("R12 reset done", 32'(done_flag), 32'd0);
        chk("R12 reset overrun", 32'(overrun), 32'd0);
        chk("R12 reset single", 32'(single_pending), 32'd0);
        chk("R7 reset irq", 32'(irq), 32'd0);
    endtask

    task automatic t_single();
        divisor = 16'd3; nine_en = 1'b0; irq_en = 1'b1;
        words[0] = 9'h0A5; words[1] = 9'h05A;
        prep(8);
        do_single();
        chk("R2 single pending after request", 32'(single_pending), 32'd1);
        wait_done("R2");
        quiet(60);
        chk("R5 lsb-first data", 32'(rd_data), 32'h0A5);
        chk("R6 bit9 zero in 8-bit mode", 32'(rd_bit9), 32'd0);
        chk("R2 exactly one word of edges", 32'(act_edges), 32'd8);
        chk("R2 single self-clears", 32'(single_pending), 32'd0);
        chk("R8 idle low after word", 32'(sclk), 32'd0);
        chk("R9 bit period div=3", 32'(t_last - t_prev), 32'd8);
        chk("R7 irq with enable", 32'(irq), 32'd1);
        do_read();
        chk("R7 read clears done", 32'(done_flag), 32'd0);
        chk("R7 irq drops after read", 32'(irq), 32'd0);
    endtask

    task automatic t_nine_fast();
        divisor = 16'd0; nine_en = 1'b1;
        words[0] = 9'h1C3;
        prep(9);
        do_single();
        wait_done("R6");
        chk("R6 low eight bits", 32'(rd_data), 32'h0C3);
        chk("R6 ninth bit", 32'(rd_bit9), 32'd1);
        chk("R9 bit period div=0", 32'(t_last - t_prev), 32'd2);
        do_read();
        nine_en = 1'b0;
    endtask

    task automatic t_cont();
        int e;
        divisor = 16'd2;
        words[0] = 9'h011; words[1] = 9'h080; words[2] = 9'h0FE; words[3] = 9'h0FF;
        prep(8);
        @(negedge clk) cont_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wait_done("R3");
            chk("R3 continuous word", 32'(rd_data), 32'(words[i][7:0]));
            do_read();
        end
        quiet(10);
        cont_en = 1'b0;
        quiet(3);
        chk("R3 abort returns sclk idle", 32'(sclk), 32'd0);
        e = act_edges;
        quiet(40);
        chk("R3 no clocks after disable", 32'(act_edges), 32'(e));
        chk("R3 abandoned word not flagged", 32'(done_flag), 32'd0);
    endtask

    task automatic t_both();
        divisor = 16'd1;
        words[0] = 9'h03C; words[1] = 9'h0C3;
        prep(8);
        @(negedge clk) begin single_set = 1'b1; cont_en = 1'b1; end
        @(negedge clk) single_set = 1'b0;
        wait_done("R4");
        chk("R4 first word", 32'(rd_data), 32'h03C);
        chk("R4 single cleared by first word", 32'(single_pending), 32'd0);
        do_read();
        wait_done("R4");
        chk("R4 continuous keeps going", 32'(rd_data), 32'h0C3);
        do_read();
        cont_en = 1'b0;
        quiet(30);
    endtask

    task automatic t_overrun();
        int e;
        divisor = 16'd1; irq_en = 1'b0;
        words[0] = 9'h001; words[1] = 9'h002; words[2] = 9'h004;
        prep(8);
        @(negedge clk) cont_en = 1'b1;
        wait_done("R7");
        chk("R7 irq gated off", 32'(irq), 32'd0);
        wait_ovr("R10");
        chk("R10 old word kept", 32'(rd_data), 32'h001);
        chk("R10 done still set", 32'(done_flag), 32'd1);
        chk("R10 sclk idle", 32'(sclk), 32'd0);
        e = act_edges;
        quiet(50);
        chk("R10 reception halted", 32'(act_edges), 32'(e));
        do_single();
        quiet(30);
        chk("R1 start blocked by overrun", 32'(act_edges), 32'(e));
        do_read();
        quiet(5);
        chk("R11 read does not clear overrun", 32'(overrun), 32'd1);
        cont_en = 1'b0;
        quiet(2);
        chk("R11 cont fall clears overrun", 32'(overrun), 32'd0);
        wait_done("R1");
        chk("R1 pending single runs after clear", 32'(rd_data), 32'h004);
        do_read();
        irq_en = 1'b1;
        quiet(20);
    endtask

    task automatic t_pol();
        @(negedge clk) clk_pol = 1'b1;
        quiet(2);
        chk("R8 idle high with pol=1", 32'(sclk), 32'd1);
        divisor = 16'd2;
        words[0] = 9'h096;
        prep(8);
        do_single();
        wait_done("R8");
        quiet(20);
        chk("R8 data with inverted clock", 32'(rd_data), 32'h096);
        chk("R8 edge count inverted", 32'(act_edges), 32'd8);
        chk("R8 returns high idle", 32'(sclk), 32'd1);
        do_read();
        clk_pol = 1'b0;
        quiet(3);
    endtask

    task automatic t_port_off();
        divisor = 16'd3;
        words[0] = 9'h0FF;
        prep(8);
        @(negedge clk) cont_en = 1'b1;
        quiet(20);
        chk("R3 partial word under way", 32'(act_edges > 0), 32'd1);
        port_en = 1'b0;
        single_set = 1'b1;
        quiet(1);
        single_set = 1'b0;
        quiet(2);
        chk("R12 port off sclk idle", 32'(sclk), 32'd0);
        chk("R12 port off done clear", 32'(done_flag), 32'd0);
        chk("R12 port off single clear", 32'(single_pending), 32'd0);
        cont_en = 1'b0;
        port_en = 1'b1;
        quiet(3);
        words[0] = 9'h06B;
        prep(8);
        @(negedge clk) cont_en = 1'b1;
        wait_done("R3");
        chk("R3 restart aligned at bit 0", 32'(rd_data), 32'h06B);
        cont_en = 1'b0;
        do_read();
        quiet(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) words[i] = '0;
        quiet(4);
        rst = 1'b0;
        quiet(2);
        t_reset();
        port_en = 1'b1;
        quiet(2);
        t_single();
        t_nine_fast();
        t_cont();
        t_both();
        t_overrun();
        t_pol();
        t_port_off();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule